// File: doc/BRIEF.md
# Smart Card Character and Block Wait Timer

This block supervises the timing of a half-duplex smart card link. All of its measurements are counted in elementary time units (ETUs), which arrive as a one-cycle tick. It watches three intervals. The first is the gap between two received characters, compared against a character wait limit. The second is the delay from the last character sent to the first character received, compared against a block wait limit. The third is the block guard time: the same turnaround must not be shorter than a guard limit.

The receiver and transmitter report the leading edge of each character with a one-cycle strobe. Each violation sets a sticky error flag. Software clears a flag by writing a one to its clear bit. A per-flag mask selects which flags drive the single interrupt line. One enable controls the character wait timer. A second enable controls the block wait and block guard timers together.

Top module: `card_wait_timer`

## Requirements
- R1: While `rst` is high at a clock edge, all timers go idle. After that edge `err_flags` reads 0 and `irq` is low.
- R2: With `cwt_en` high, the ETU count restarts at 0 on every `rx_char`. The character wait flag (`err_flags` bit 0) sets on the edge of the tick that brings the count to `cwt_limit`+1 with no `rx_char` in between. Exactly `cwt_limit` ticks raise no error.
- R3: When `cwt_en` is low, the character timer is idle and bit 0 cannot set. An `rx_char` then does not arm it. After one character wait error the timer stays stopped until the next `rx_char`.
- R4: With `blk_en` high, a `tx_char` restarts the block count at 0. If `bwt_limit`+1 ticks pass with no `rx_char` or `tx_char`, the block wait flag (`err_flags` bit 1) sets on the edge of that tick.
- R5: The first `rx_char` after a `tx_char` stops the block timer. Later ticks raise no block wait error until the next `tx_char`.
- R6: The block guard flag (`err_flags` bit 2) sets on the edge of an `rx_char` that arrives while the block timer runs with an elapsed count below `bgt_limit`. A count equal to or above `bgt_limit` raises no error, and neither does an `rx_char` while the timer is stopped.
- R7: When `blk_en` is low, the block timer is idle and `tx_char` is ignored. Bits 1 and 2 cannot set.
- R8: Every flag holds until a one is applied to the matching bit of `clr_err` (bit 0 character wait, bit 1 block wait, bit 2 block guard). A set and a clear of the same flag in one cycle leaves the flag set.
- R9: `irq` is high in the same cycle in which any bit of `err_flags & ~err_mask` is 1, and low otherwise.
- R10: When an `rx_char` and a tick come in the same cycle, the tick is not counted after the restart. When `rx_char` and `tx_char` come in the same cycle, the guard check uses the count held before that edge, and the block timer then restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle pulse per ETU |
| rx_char | input | 1 | Leading edge of a received character |
| tx_char | input | 1 | Leading edge of a transmitted character |
| cwt_en | input | 1 | Character wait timer enable |
| blk_en | input | 1 | Block wait and block guard enable |
| cwt_limit | input | 16 | Character wait limit in ETUs |
| bwt_limit | input | 32 | Block wait limit in ETUs |
| bgt_limit | input | 16 | Minimum block guard time in ETUs |
| clr_err | input | 3 | Write-one-to-clear, one bit per flag |
| err_mask | input | 3 | 1 masks the flag from irq |
| err_flags | output | 3 | Sticky flags: bit0 char wait, bit1 block wait, bit2 block guard |
| irq | output | 1 | OR of unmasked flags |

## Verification
The hardest situations to reach from the ports are the coincidences. These include a character edge in the same cycle as a tick, a new transmission in the same cycle as a reception, and a flag being set in the cycle software clears it. Each needs two strobes to line up exactly at a limit. Directed sequences place these collisions on purpose, using small limits and counted ticks. A long random run then uses small random limits and dense strobes, so that such collisions recur many times and are compared cycle by cycle against a bench model.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

    localparam int N_ERR   = 3;
    localparam int ERR_CWT = 0;
    localparam int ERR_BWT = 1;
    localparam int ERR_BGT = 2;

    typedef logic [N_ERR-1:0] err_vec_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic cwt;
        logic bwt;
        logic bgt;
    } err_evt_t;

    function automatic err_vec_t evt_to_vec(input err_evt_t e);
        err_vec_t v;
        v          = '0;
        v[ERR_CWT] = e.cwt;
        v[ERR_BWT] = e.bwt;
        v[ERR_BGT] = e.bgt;
        return v;
    endfunction

endpackage

// File: rtl/char_gap_timer.sv
module char_gap_timer
    import cwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             rx,
    input  logic [CNT_W-1:0] limit,
    output logic             err_pulse
);

    tmr_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             at_limit;

    assign at_limit  = (cnt == limit);
    assign err_pulse = en && !rx && (st == TMR_RUN) && tick && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= TMR_IDLE;
            cnt <= '0;
        end else if (rx) begin
            st  <= TMR_RUN;
            cnt <= '0;
        end else if (st == TMR_RUN && tick) begin
            if (at_limit) begin
                st <= TMR_IDLE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/block_wait_timer.sv
module block_wait_timer
    import cwt_pkg::*;
#(
    parameter int BW_W = 32,
    parameter int BG_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic            rx,
    input  logic            tx,
    input  logic [BW_W-1:0] bwt_limit,
    input  logic [BG_W-1:0] bgt_limit,
    output logic            bwt_pulse,
    output logic            bgt_pulse
);

    localparam int CMP_W = (BW_W > BG_W) ? BW_W : BG_W;

    tmr_state_e      st;
    logic [BW_W-1:0] cnt;
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] guard_ext;
    logic            running;

    assign running   = (st == TMR_RUN);
    assign cnt_ext   = CMP_W'(cnt);
    assign guard_ext = CMP_W'(bgt_limit);
    assign bgt_pulse = en && rx && running && (cnt_ext < guard_ext);
    assign bwt_pulse = en && !rx && !tx && running && tick && (cnt == bwt_limit);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= TMR_IDLE;
            cnt <= '0;
        end else if (tx) begin
            st  <= TMR_RUN;
            cnt <= '0;
        end else if (rx) begin
            st  <= TMR_IDLE;
        end else if (running && tick) begin
            if (cnt == bwt_limit) begin
                st <= TMR_IDLE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
        assign live[i] = flags[i] && !mask[i];
    end

    assign irq = |live;

endmodule

// File: rtl/card_wait_timer.sv
module card_wait_timer
    import cwt_pkg::*;
#(
    parameter int CWT_W = 16,
    parameter int BWT_W = 32,
    parameter int BGT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             etu_tick,
    input  logic             rx_char,
    input  logic             tx_char,
    input  logic             cwt_en,
    input  logic             blk_en,
    input  logic [CWT_W-1:0] cwt_limit,
    input  logic [BWT_W-1:0] bwt_limit,
    input  logic [BGT_W-1:0] bgt_limit,
    input  logic [2:0]       clr_err,
    input  logic [2:0]       err_mask,
    output logic [2:0]       err_flags,
    output logic             irq
);

    err_evt_t evt;

    char_gap_timer #(.CNT_W(CWT_W)) i_char_gap (
        .clk       (clk),
        .rst       (rst),
        .en        (cwt_en),
        .tick      (etu_tick),
        .rx        (rx_char),
        .limit     (cwt_limit),
        .err_pulse (evt.cwt)
    );

    block_wait_timer #(.BW_W(BWT_W), .BG_W(BGT_W)) i_block (
        .clk       (clk),
        .rst       (rst),
        .en        (blk_en),
        .tick      (etu_tick),
        .rx        (rx_char),
        .tx        (tx_char),
        .bwt_limit (bwt_limit),
        .bgt_limit (bgt_limit),
        .bwt_pulse (evt.bwt),
        .bgt_pulse (evt.bgt)
    );

    err_flag_bank #(.N(N_ERR)) i_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (evt_to_vec(evt)),
        .clr     (clr_err),
        .mask    (err_mask),
        .flags   (err_flags),
        .irq     (irq)
    );

endmodule

// File: rtl/cwt_checker.sv
module cwt_checker (
    input logic       clk,
    input logic       rst,
    input logic       etu_tick,
    input logic       rx_char,
    input logic       tx_char,
    input logic       cwt_en,
    input logic       blk_en,
    input logic [2:0] clr_err,
    input logic [2:0] err_mask,
    input logic [2:0] err_flags,
    input logic       irq
);

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (err_flags == 3'b000));

    a_r3_cwt_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[0]) |-> $past(cwt_en && etu_tick && !rx_char));

    a_r4_bwt_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[1]) |-> $past(blk_en && etu_tick && !rx_char && !tx_char));

    a_r6_bgt_on_rx: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[2]) |-> $past(blk_en && rx_char));

    a_r8_sticky_cwt: assert property (@(posedge clk) disable iff (rst)
        (err_flags[0] && !clr_err[0]) |=> err_flags[0]);

    a_r8_sticky_bwt: assert property (@(posedge clk) disable iff (rst)
        (err_flags[1] && !clr_err[1]) |=> err_flags[1]);

    a_r8_sticky_bgt: assert property (@(posedge clk) disable iff (rst)
        (err_flags[2] && !clr_err[2]) |=> err_flags[2]);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (err_flags != 3'b000));

    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (err_mask == 3'b111) |-> !irq);

endmodule

bind card_wait_timer cwt_checker i_cwt_checker (
    .clk       (clk),
    .rst       (rst),
    .etu_tick  (etu_tick),
    .rx_char   (rx_char),
    .tx_char   (tx_char),
    .cwt_en    (cwt_en),
    .blk_en    (blk_en),
    .clr_err   (clr_err),
    .err_mask  (err_mask),
    .err_flags (err_flags),
    .irq       (irq)
);

// File: tb/test_card_wait_timer.sv
module test_card_wait_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        etu_tick, rx_char, tx_char, cwt_en, blk_en;
    logic [15:0] cwt_limit;
    logic [31:0] bwt_limit;
    logic [15:0] bgt_limit;
    logic [2:0]  clr_err, err_mask, err_flags;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench reference state
    int unsigned m_cc, m_bc;
    bit          m_carm, m_brun;
    bit [2:0]    m_f;

    always #5 clk = ~clk;

    card_wait_timer i_card_wait_timer (
        .clk(clk), .rst(rst), .etu_tick(etu_tick), .rx_char(rx_char), .tx_char(tx_char),
        .cwt_en(cwt_en), .blk_en(blk_en), .cwt_limit(cwt_limit), .bwt_limit(bwt_limit),
        .bgt_limit(bgt_limit), .clr_err(clr_err), .err_mask(err_mask),
        .err_flags(err_flags), .irq(irq)
    );

    function automatic bit exp_irq(input bit [2:0] f, input bit [2:0] m);
        return |(f & ~m);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference update from the inputs present before the edge
    task automatic model_step();
        bit [2:0] s;
        s = '0;
        if (rst) begin
            m_carm = 0; m_cc = 0; m_brun = 0; m_bc = 0; m_f = '0;
            return;
        end
        if (!cwt_en) begin
            m_carm = 0; m_cc = 0;
        end else if (rx_char) begin
            m_carm = 1; m_cc = 0;
        end else if (m_carm && etu_tick) begin
            if (m_cc == cwt_limit) begin s[0] = 1; m_carm = 0; end
            else m_cc++;
        end
        if (!blk_en) begin
            m_brun = 0; m_bc = 0;
        end else begin
            if (rx_char && m_brun && m_bc < bgt_limit) s[2] = 1;
            if (tx_char) begin
                m_brun = 1; m_bc = 0;
            end else if (rx_char) begin
                m_brun = 0;
            end else if (m_brun && etu_tick) begin
                if (m_bc == bwt_limit) begin s[1] = 1; m_brun = 0; end
                else m_bc++;
            end
        end
        m_f = (m_f & ~clr_err) | s;
    endtask

    // one clock: drive at negedge, compare at the next negedge
    task automatic cyc(input bit t, input bit r, input bit x, input bit [2:0] c, input string tag);
        etu_tick = t; rx_char = r; tx_char = x; clr_err = c;
        model_step();
        @(posedge clk);
        @(negedge clk);
        etu_tick = 0; rx_char = 0; tx_char = 0; clr_err = '0;
        chk({tag, " flags"}, {29'd0, err_flags}, {29'd0, m_f});
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq(m_f, err_mask)});
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 3'b000, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; etu_tick = 0; rx_char = 0; tx_char = 0; clr_err = '0;
        cwt_en = 0; blk_en = 0; err_mask = '0;
        cwt_limit = 16'd3; bwt_limit = 32'd5; bgt_limit = 16'd3;
        @(negedge clk);
        cyc(0, 0, 0, 3'b000, "R1");
        cyc(1, 1, 1, 3'b000, "R1");
        chk("R1 flags after reset", {29'd0, err_flags}, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rst = 0;

        // character wait
        cwt_en = 1;
        cyc(0, 1, 0, 3'b000, "R2");
        ticks(3, "R2");
        chk("R2 no error at exact limit", {31'd0, err_flags[0]}, 32'd0);
        cyc(0, 1, 0, 3'b000, "R3");
        ticks(4, "R2");
        chk("R2 error after limit+1", {31'd0, err_flags[0]}, 32'd1);
        ticks(6, "R3");
        cyc(0, 0, 0, 3'b001, "R8");
        chk("R8 clear char flag", {29'd0, err_flags}, 32'd0);
        // set wins over clear
        cwt_limit = 16'd0;
        cyc(0, 1, 0, 3'b000, "R8");
        cyc(1, 0, 0, 3'b001, "R8");
        chk("R8 set beats clear", {31'd0, err_flags[0]}, 32'd1);
        cyc(0, 0, 0, 3'b001, "R8");
        // rx with tick in the same cycle
        cwt_limit = 16'd1;
        cyc(0, 1, 0, 3'b000, "R10");
        cyc(1, 0, 0, 3'b000, "R10");
        cyc(1, 1, 0, 3'b000, "R10");
        cyc(1, 0, 0, 3'b000, "R10");
        chk("R10 tick on rx not counted", {31'd0, err_flags[0]}, 32'd0);
        cyc(1, 0, 0, 3'b000, "R10");
        chk("R10 error after restart", {31'd0, err_flags[0]}, 32'd1);
        cyc(0, 0, 0, 3'b001, "R8");
        // disabled
        cwt_en = 0;
        cyc(0, 1, 0, 3'b000, "R3");
        ticks(8, "R3");
        chk("R3 disabled no char error", {31'd0, err_flags[0]}, 32'd0);

        // block guard and block wait
        blk_en = 1; bwt_limit = 32'd5; bgt_limit = 16'd3;
        cyc(0, 0, 1, 3'b000, "R6");
        ticks(2, "R6");
        cyc(0, 1, 0, 3'b000, "R6");
        chk("R6 short guard flagged", {31'd0, err_flags[2]}, 32'd1);
        cyc(0, 0, 0, 3'b100, "R8");
        cyc(0, 0, 1, 3'b000, "R6");
        ticks(3, "R6");
        cyc(0, 1, 0, 3'b000, "R6");
        chk("R6 guard equal to limit ok", {31'd0, err_flags[2]}, 32'd0);
        ticks(10, "R5");
        cyc(0, 1, 0, 3'b000, "R6");
        chk("R5 stopped, no block wait", {29'd0, err_flags}, 32'd0);
        cyc(0, 0, 1, 3'b000, "R4");
        ticks(5, "R4");
        chk("R4 no error at limit", {31'd0, err_flags[1]}, 32'd0);
        ticks(1, "R4");
        chk("R4 block wait error", {31'd0, err_flags[1]}, 32'd1);
        cyc(0, 0, 0, 3'b010, "R8");
        // rx and tx together
        cyc(0, 0, 1, 3'b000, "R10");
        ticks(1, "R10");
        cyc(0, 1, 1, 3'b000, "R10");
        chk("R10 guard uses old count", {31'd0, err_flags[2]}, 32'd1);
        ticks(6, "R10");
        chk("R10 block timer restarted", {31'd0, err_flags[1]}, 32'd1);
        cyc(0, 0, 0, 3'b110, "R8");
        // block disabled
        blk_en = 0;
        cyc(0, 0, 1, 3'b000, "R7");
        ticks(8, "R7");
        cyc(0, 1, 0, 3'b000, "R7");
        chk("R7 disabled no block error", {29'd0, err_flags}, 32'd0);

        // interrupt masking
        cwt_en = 1; cwt_limit = 16'd0;
        cyc(0, 1, 0, 3'b000, "R9");
        cyc(1, 0, 0, 3'b000, "R9");
        err_mask = 3'b001;
        #1 chk("R9 masked irq low", {31'd0, irq}, 32'd0);
        err_mask = 3'b110;
        #1 chk("R9 unmasked irq high", {31'd0, irq}, 32'd1);
        cyc(0, 0, 0, 3'b001, "R8");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            if (($urandom % 64) == 0) begin
                cwt_en = $urandom % 4 != 0;
                blk_en = $urandom % 4 != 0;
                cwt_limit = 16'($urandom % 6);
                bwt_limit = 32'($urandom % 9);
                bgt_limit = 16'($urandom % 5);
            end
            if (($urandom % 16) == 0) err_mask = 3'($urandom);
            cyc(($urandom % 2) == 0, ($urandom % 7) == 0, ($urandom % 11) == 0,
                (($urandom % 12) == 0) ? 3'($urandom) : 3'b000, "RAND R2 R4 R6 R8");
        end

        rst = 1;
        cyc(0, 0, 0, 3'b000, "R1");
        chk("R1 reset clears flags", {29'd0, err_flags}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule